// File: doc/BRIEF.md
# Shared-Memory Byte Ring Client

This block is one end of a byte ring buffer held in external memory that a processor also uses. The ring has a three-byte header just below its data area. From low to high address the header holds a wrap mask (ring length minus one), the producer index and the consumer index. The client keeps its own copy of the mask and of both indices. It decides emptiness and fullness by comparing its own copy against the index it reads fresh from memory. After every byte it moves, it writes the index it owns back into the header.

Every memory access happens while the client holds the bus. It asks an external ownership controller for the bus with `bus_req` and waits for `bus_gnt`. It then issues single-byte memory cycles, each finished by `mem_ack`. Afterwards it drops the request and waits for the grant to go away. A status check takes one ownership period and a byte transfer takes a second one, so the processor can run between them. Header loading starts with `init_req`. A consumer holds `rx_ready` until `rx_valid` pulses with a byte. A producer holds `tx_valid` with `tx_data` until `tx_ready` pulses.

Top module: `ring_fifo_client`

## Requirements
- R1: A one-cycle `init_req` while idle and with a nonzero base makes the client take the bus and read base−3, base−2 and base−1 in that order. These three reads load the local mask, producer index and consumer index. The client then releases the bus.
- R2: A pop first reads the producer index at base−2. The result is empty when that byte equals the local consumer index, and `stat_empty` holds the result of the latest such check.
- R3: A push first reads the consumer index at base−1. The result is full when (local producer index + 1) AND mask equals that byte, and `stat_full` holds the result of the latest such check.
- R4: After a not-empty check, the client takes a second bus ownership. In it, it reads the byte at base + consumer index, then writes (consumer index + 1) AND mask to base−1. After release, it presents the byte on `rx_data` with a one-cycle `rx_valid`.
- R5: After a not-full check, the client takes a second bus ownership. In it, it writes `tx_data` to base + producer index, then writes (producer index + 1) AND mask to base−2. After release, it pulses `tx_ready` for one cycle.
- R6: While `base_addr` is zero, `stat_empty` and `stat_full` both read 1, and `init_req`, `rx_ready` and `tx_valid` raise no bus request.
- R7: `mem_req` is high only while `bus_req` and `bus_gnt` are both high. Once raised, it holds with a stable address until `mem_ack`.
- R8: Between the status check and the transfer, `bus_req` falls and the client waits for `bus_gnt` to fall, so a successful pop or push raises `bus_req` exactly twice. Completion is signalled only after release.
- R9: When more than one operation is pending in idle, init wins over pop and pop wins over push.
- R10: After reset, `bus_req`, `mem_req`, `rx_valid` and `tx_ready` are low, and `stat_empty` and `stat_full` are high.
- R11: A pop that finds the ring empty delivers no byte and leaves the consumer index in memory untouched. It retries with a fresh check for as long as `rx_ready` stays high.
- R12: Indices wrap under the mask, so the consumer index at mask − 0 advances to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_addr | input | AW | Address of ring byte 0; zero means no ring |
| init_req | input | 1 | Load the header into local registers |
| rx_ready | input | 1 | Consumer wants one byte |
| rx_valid | output | 1 | One-cycle pulse: `rx_data` holds a popped byte |
| rx_data | output | 8 | Popped byte |
| tx_valid | input | 1 | Producer offers `tx_data` |
| tx_ready | output | 1 | One-cycle pulse: offered byte is stored |
| tx_data | input | 8 | Byte to push |
| stat_empty | output | 1 | Result of the latest empty check |
| stat_full | output | 1 | Result of the latest full check |
| bus_req | output | 1 | Request for bus ownership |
| bus_gnt | input | 1 | Bus ownership granted |
| mem_req | output | 1 | Memory cycle request, held until acknowledged |
| mem_we | output | 1 | 1 = write cycle, 0 = read cycle |
| mem_addr | output | AW | Memory cycle address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory cycle complete |

## Verification
The bench sweeps every start position of an eight-byte ring against every fill level, for both pops and pushes. This reaches the wrap from index 7 to 0 and the gap of one free slot. A design that tested fullness without the +1, or that forgot the mask, would accept one byte too many or write past the ring end. Each drained or filled ring is followed by one more attempt. A design that compared the wrong pair of indices would return a stale byte or move a header index it must leave alone. The bench also counts bus ownerships per transfer to catch a transfer merged into its check, and drives all requests at once to catch a wrong priority.

// File: rtl/ring_pkg.sv
package ring_pkg;
  localparam int RING_DW = 8;
  // Header distances below the ring base; the order is fixed by the shared layout.
  localparam int HDR_MASK_DIST = 3;
  localparam int HDR_IN_DIST   = 2;
  localparam int HDR_OUT_DIST  = 1;

  typedef logic [RING_DW-1:0] ring_byte_t;

  typedef enum logic [1:0] {OP_INIT, OP_POP, OP_PUSH} ring_op_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ACQ, ST_HMASK, ST_HIN, ST_HOUT, ST_CHK, ST_DAT, ST_IDX, ST_REL
  } ring_st_e;

  function automatic ring_byte_t ring_next(input ring_byte_t idx, input ring_byte_t mask);
    ring_byte_t inc;
    inc = idx + 1'b1;
    return inc & mask;
  endfunction
endpackage

// File: rtl/ring_cache.sv
module ring_cache
  import ring_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld_mask,
  input  logic       ld_in,
  input  logic       ld_out,
  input  ring_byte_t rd_byte,
  input  logic       chk_empty_ev,
  input  logic       chk_full_ev,
  input  logic       adv_in,
  input  logic       adv_out,
  output ring_byte_t mask_q,
  output ring_byte_t in_q,
  output ring_byte_t out_q,
  output logic       hit_empty,
  output logic       hit_full,
  output logic       empty_q,
  output logic       full_q
);
  // Compare the freshly read shared index with the local copy.
  assign hit_empty = (rd_byte == out_q);
  assign hit_full  = (ring_next(in_q, mask_q) == rd_byte);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      in_q    <= '0;
      out_q   <= '0;
      empty_q <= 1'b1;
      full_q  <= 1'b1;
    end else begin
      if (ld_mask)      mask_q  <= rd_byte;
      if (ld_in)        in_q    <= rd_byte;
      else if (adv_in)  in_q    <= ring_next(in_q, mask_q);
      if (ld_out)       out_q   <= rd_byte;
      else if (adv_out) out_q   <= ring_next(out_q, mask_q);
      if (chk_empty_ev) empty_q <= hit_empty;
      if (chk_full_ev)  full_q  <= hit_full;
    end
  end
endmodule

// File: rtl/ring_ctrl.sv
module ring_ctrl
  import ring_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base_addr,
  input  logic          base_zero,
  input  logic          init_req,
  input  logic          rx_ready,
  input  logic          tx_valid,
  input  ring_byte_t    tx_data,
  input  logic          bus_gnt,
  input  logic          mem_ack,
  input  ring_byte_t    mem_rdata,
  input  ring_byte_t    mask_q,
  input  ring_byte_t    in_q,
  input  ring_byte_t    out_q,
  input  logic          hit_empty,
  input  logic          hit_full,
  output logic          bus_req,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output ring_byte_t    mem_wdata,
  output logic          rx_valid,
  output ring_byte_t    rx_data,
  output logic          tx_ready,
  output logic          ld_mask,
  output logic          ld_in,
  output logic          ld_out,
  output logic          chk_empty_ev,
  output logic          chk_full_ev,
  output logic          adv_in,
  output logic          adv_out
);
  localparam logic [AW-1:0] DIST_MASK = AW'(HDR_MASK_DIST);
  localparam logic [AW-1:0] DIST_IN   = AW'(HDR_IN_DIST);
  localparam logic [AW-1:0] DIST_OUT  = AW'(HDR_OUT_DIST);

  ring_st_e   st_q;
  ring_op_e   op_q;
  logic       xfer_q, go_q;
  ring_byte_t tx_hold_q;

  logic is_pop, acked;
  logic [AW-1:0] a_mask, a_in, a_out, a_dat;

  assign is_pop = (op_q == OP_POP);
  assign acked  = mem_req && mem_ack;
  assign a_mask = base_addr - DIST_MASK;
  assign a_in   = base_addr - DIST_IN;
  assign a_out  = base_addr - DIST_OUT;
  assign a_dat  = base_addr + AW'(is_pop ? out_q : in_q);

  always_comb begin
    bus_req   = st_q inside {ST_ACQ, ST_HMASK, ST_HIN, ST_HOUT, ST_CHK, ST_DAT, ST_IDX};
    mem_req   = st_q inside {ST_HMASK, ST_HIN, ST_HOUT, ST_CHK, ST_DAT, ST_IDX};
    mem_we    = 1'b0;
    mem_addr  = a_mask;
    mem_wdata = '0;
    case (st_q)
      ST_HIN:  mem_addr = a_in;
      ST_HOUT: mem_addr = a_out;
      ST_CHK:  mem_addr = is_pop ? a_in : a_out;
      ST_DAT: begin
        mem_addr  = a_dat;
        mem_we    = !is_pop;
        mem_wdata = tx_hold_q;
      end
      ST_IDX: begin
        mem_addr  = is_pop ? a_out : a_in;
        mem_we    = 1'b1;
        mem_wdata = is_pop ? ring_next(out_q, mask_q) : ring_next(in_q, mask_q);
      end
      default: ;
    endcase
  end

  assign ld_mask      = acked && (st_q == ST_HMASK);
  assign ld_in        = acked && (st_q == ST_HIN);
  assign ld_out       = acked && (st_q == ST_HOUT);
  assign chk_empty_ev = acked && (st_q == ST_CHK) && is_pop;
  assign chk_full_ev  = acked && (st_q == ST_CHK) && !is_pop;
  assign adv_out      = acked && (st_q == ST_IDX) && is_pop;
  assign adv_in       = acked && (st_q == ST_IDX) && !is_pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      op_q      <= OP_INIT;
      xfer_q    <= 1'b0;
      go_q      <= 1'b0;
      tx_hold_q <= '0;
      rx_data   <= '0;
      rx_valid  <= 1'b0;
      tx_ready  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      tx_ready <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          xfer_q <= 1'b0;
          go_q   <= 1'b0;
          if (!base_zero) begin
            if (init_req) begin
              op_q <= OP_INIT;
              st_q <= ST_ACQ;
            end else if (rx_ready) begin
              op_q <= OP_POP;
              st_q <= ST_ACQ;
            end else if (tx_valid) begin
              op_q      <= OP_PUSH;
              tx_hold_q <= tx_data;
              st_q      <= ST_ACQ;
            end
          end
        end
        ST_ACQ: if (bus_gnt)
          st_q <= (op_q == OP_INIT) ? ST_HMASK : (xfer_q ? ST_DAT : ST_CHK);
        ST_HMASK: if (acked) st_q <= ST_HIN;
        ST_HIN:   if (acked) st_q <= ST_HOUT;
        ST_HOUT:  if (acked) st_q <= ST_REL;
        ST_CHK: if (acked) begin
          go_q <= is_pop ? !hit_empty : !hit_full;
          st_q <= ST_REL;
        end
        ST_DAT: if (acked) begin
          if (is_pop) rx_data <= mem_rdata;
          st_q <= ST_IDX;
        end
        ST_IDX: if (acked) st_q <= ST_REL;
        ST_REL: if (!bus_gnt) begin
          if (go_q) begin
            go_q   <= 1'b0;
            xfer_q <= 1'b1;
            st_q   <= ST_ACQ;
          end else begin
            if (xfer_q) begin
              rx_valid <= is_pop;
              tx_ready <= (op_q == OP_PUSH);
            end
            xfer_q <= 1'b0;
            st_q   <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ring_fifo_client.sv
module ring_fifo_client
  import ring_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      base_addr,
  input  logic               init_req,
  input  logic               rx_ready,
  output logic               rx_valid,
  output logic [RING_DW-1:0] rx_data,
  input  logic               tx_valid,
  output logic               tx_ready,
  input  logic [RING_DW-1:0] tx_data,
  output logic               stat_empty,
  output logic               stat_full,
  output logic               bus_req,
  input  logic               bus_gnt,
  output logic               mem_req,
  output logic               mem_we,
  output logic [AW-1:0]      mem_addr,
  output logic [RING_DW-1:0] mem_wdata,
  input  logic [RING_DW-1:0] mem_rdata,
  input  logic               mem_ack
);
  // Named internal events between sequencer and index cache.
  logic       base_zero;
  logic       ld_mask, ld_in, ld_out;
  logic       chk_empty_ev, chk_full_ev, adv_in, adv_out;
  logic       hit_empty, hit_full, empty_q, full_q;
  ring_byte_t mask_q, in_q, out_q;

  assign base_zero  = (base_addr == '0);
  assign stat_empty = base_zero || empty_q;
  assign stat_full  = base_zero || full_q;

  ring_cache u_cache (
    .clk(clk), .rst_n(rst_n),
    .ld_mask(ld_mask), .ld_in(ld_in), .ld_out(ld_out),
    .rd_byte(mem_rdata),
    .chk_empty_ev(chk_empty_ev), .chk_full_ev(chk_full_ev),
    .adv_in(adv_in), .adv_out(adv_out),
    .mask_q(mask_q), .in_q(in_q), .out_q(out_q),
    .hit_empty(hit_empty), .hit_full(hit_full),
    .empty_q(empty_q), .full_q(full_q)
  );

  ring_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .base_addr(base_addr), .base_zero(base_zero),
    .init_req(init_req), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data),
    .bus_gnt(bus_gnt), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .mask_q(mask_q), .in_q(in_q), .out_q(out_q),
    .hit_empty(hit_empty), .hit_full(hit_full),
    .bus_req(bus_req), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .tx_ready(tx_ready),
    .ld_mask(ld_mask), .ld_in(ld_in), .ld_out(ld_out),
    .chk_empty_ev(chk_empty_ev), .chk_full_ev(chk_full_ev),
    .adv_in(adv_in), .adv_out(adv_out)
  );
endmodule

// File: rtl/ring_fifo_client_chk.sv
module ring_fifo_client_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] base_addr,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic          mem_req,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic          rx_valid,
  input logic          tx_ready,
  input logic          stat_empty,
  input logic          stat_full
);
  assert_mem_owned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (bus_req && bus_gnt));

  assert_mem_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  assert_zero_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (base_addr == '0) |-> (stat_empty && stat_full));

  assert_pop_checked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !stat_empty);

  assert_push_checked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !stat_full);

  assert_done_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid || tx_ready) |-> !bus_req);

  assert_single_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_valid, tx_ready}));
endmodule

bind ring_fifo_client ring_fifo_client_chk #(.AW(AW)) u_chk (.*);

// File: tb/ring_fifo_client_bench.sv
module ring_fifo_client_bench;
  localparam int AW = 16;
  localparam int BASE = 16'h0104;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic init_req = 0, rx_ready = 0, tx_valid = 0;
  logic [7:0] tx_data = '0;
  logic rx_valid, tx_ready, stat_empty, stat_full, bus_req, mem_req, mem_we;
  logic [7:0] rx_data, mem_wdata;
  logic [AW-1:0] mem_addr;
  logic bus_gnt = 0, mem_ack = 0;
  logic [7:0] mem_rdata = '0;
  logic [7:0] mem [0:511];

  int n_chk = 0, n_fail = 0;
  int rises = 0, viol = 0;
  logic breq_d = 0;
  bit log_en = 0;
  int log_n = 0;
  int log_a [0:2];
  bit cap_en = 0, cap_done = 0;
  int cap_addr = 0;

  always #4 clk = ~clk;

  ring_fifo_client #(.AW(AW)) u_ring_fifo_client (
    .clk(clk), .rst_n(rst_n), .base_addr(base_addr), .init_req(init_req),
    .rx_ready(rx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .stat_empty(stat_empty), .stat_full(stat_full),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack)
  );

  // Ownership controller and memory model.
  always @(posedge clk) begin
    if (!rst_n) begin
      bus_gnt <= 0; mem_ack <= 0; breq_d <= 0;
    end else begin
      bus_gnt <= bus_req;
      breq_d  <= bus_req;
      if (bus_req && !breq_d) rises <= rises + 1;
      if (mem_req && !bus_gnt) viol <= viol + 1;
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        if (mem_we) mem[mem_addr[8:0]] <= mem_wdata;
        else mem_rdata <= mem[mem_addr[8:0]];
        if (log_en && log_n < 3) begin
          log_a[log_n] <= int'(mem_addr);
          log_n <= log_n + 1;
        end
        if (cap_en && !cap_done) begin
          cap_addr <= int'(mem_addr);
          cap_done <= 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_hdr(input int mask, input int in_i, input int out_i);
    mem[BASE-3] = 8'(mask);
    mem[BASE-2] = 8'(in_i);
    mem[BASE-1] = 8'(out_i);
  endtask

  task automatic do_init();
    @(negedge clk) init_req = 1;
    @(negedge clk) init_req = 0;
    repeat (30) @(negedge clk);
  endtask

  task automatic pop_one(output logic [7:0] d, output bit got, input int lim);
    got = 0; d = '0;
    rx_ready = 1;
    for (int i = 0; i < lim && !got; i++) begin
      @(negedge clk);
      if (rx_valid) begin got = 1; d = rx_data; end
    end
    rx_ready = 0;
    if (!got) repeat (40) @(negedge clk);
  endtask

  task automatic push_one(input logic [7:0] v, output bit got, input int lim);
    got = 0;
    tx_valid = 1; tx_data = v;
    for (int i = 0; i < lim && !got; i++) begin
      @(negedge clk);
      if (tx_ready) got = 1;
    end
    tx_valid = 0;
    if (!got) repeat (40) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    bit got;
    int r0;
    for (int i = 0; i < 512; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!bus_req && !mem_req, "R10 bus idle", bus_req, 0);
    chk(!rx_valid && !tx_ready, "R10 no done", rx_valid, 0);
    chk(stat_empty && stat_full, "R10 status", stat_empty, 1);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R6 zero base
    r0 = rises;
    init_req = 1; rx_ready = 1; tx_valid = 1;
    repeat (20) @(negedge clk);
    init_req = 0; rx_ready = 0; tx_valid = 0;
    chk(rises == r0, "R6 no bus request", rises - r0, 0);
    chk(stat_empty && stat_full, "R6 status", {stat_empty, stat_full}, 3);

    // R1 header load order
    base_addr = AW'(BASE);
    set_hdr(7, 0, 0);
    r0 = rises;
    log_en = 1;
    do_init();
    log_en = 0;
    chk(log_a[0] == BASE-3, "R1 first read", log_a[0], BASE-3);
    chk(log_a[1] == BASE-2, "R1 second read", log_a[1], BASE-2);
    chk(log_a[2] == BASE-1, "R1 third read", log_a[2], BASE-1);
    chk(rises - r0 == 1 && !bus_req, "R1 one ownership", rises - r0, 1);

    // Pop sweep: every start, every fill level
    for (int st = 0; st < 8; st++) begin
      for (int n = 0; n < 8; n++) begin
        for (int k = 0; k < 8; k++) mem[BASE+k] = 8'(st*32 + k*5 + 7 + n);
        set_hdr(7, (st+n) & 7, st);
        do_init();
        for (int i = 0; i < n; i++) begin
          int exp;
          exp = (st*32 + ((st+i) & 7)*5 + 7 + n) & 255;
          r0 = rises;
          pop_one(d, got, 200);
          chk(got && d == 8'(exp), "R4 pop data", int'(d), exp);
          chk(rises - r0 == 2, "R8 two ownerships", rises - r0, 2);
          chk(!stat_empty, "R2 not empty", stat_empty, 0);
        end
        chk(mem[BASE-1] == 8'((st+n) & 7), "R4 out index", mem[BASE-1], (st+n) & 7);
        if (st + n > 7)
          chk(mem[BASE-1] == 8'((st+n) & 7), "R12 wrap", mem[BASE-1], (st+n) & 7);
        pop_one(d, got, 60);
        chk(!got, "R11 no byte when empty", got, 0);
        chk(stat_empty, "R2 empty seen", stat_empty, 1);
        chk(mem[BASE-1] == 8'((st+n) & 7), "R11 index kept", mem[BASE-1], (st+n) & 7);
      end
    end

    // Push sweep: every start, every free-space amount
    for (int st = 0; st < 8; st++) begin
      for (int dd = 0; dd < 8; dd++) begin
        int outi, room;
        outi = (st + dd) & 7;
        room = (outi - st - 1 + 16) & 7;
        set_hdr(7, st, outi);
        do_init();
        for (int i = 0; i < room; i++) begin
          logic [7:0] v;
          v = 8'(st*16 + i*9 + 3 + dd);
          push_one(v, got, 200);
          chk(got, "R5 push accepted", got, 1);
          chk(mem[BASE + ((st+i) & 7)] == v, "R5 byte stored",
              mem[BASE + ((st+i) & 7)], int'(v));
        end
        push_one(8'hEE, got, 60);
        chk(!got, "R3 refused when full", got, 0);
        chk(stat_full, "R3 full seen", stat_full, 1);
        chk(mem[BASE-2] == 8'((st+room) & 7), "R5 in index", mem[BASE-2], (st+room) & 7);
      end
    end

    // R9 priority: pop before push
    mem[BASE+0] = 8'h11; mem[BASE+1] = 8'h22;
    set_hdr(7, 2, 0);
    do_init();
    cap_en = 1;
    @(negedge clk);
    rx_ready = 1; tx_valid = 1; tx_data = 8'hA5;
    got = 0;
    for (int i = 0; i < 200 && !got; i++) begin
      @(negedge clk);
      if (rx_valid) begin got = 1; d = rx_data; end
    end
    rx_ready = 0;
    chk(cap_addr == BASE-2, "R9 pop checked first", cap_addr, BASE-2);
    chk(got && d == 8'h11, "R9 pop data", int'(d), 17);
    got = 0;
    for (int i = 0; i < 200 && !got; i++) begin
      @(negedge clk);
      if (tx_ready) got = 1;
    end
    tx_valid = 0;
    chk(got && mem[BASE+2] == 8'hA5, "R9 push after pop", mem[BASE+2], 165);

    repeat (5) @(negedge clk);
    chk(viol == 0, "R7 access without grant", viol, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule